// File: doc/BRIEF.md
# Grayscale PWM Counter Generator

This block turns sixteen 12-bit brightness codes into sixteen pulse-width-modulated channel enables. All channels share one free-running grayscale counter that is clocked by the grayscale reference clock. A high level on `blank` holds the counter at zero and forces every enable low. Lowering `blank` starts a new grayscale cycle. At the first clock edge after that, every channel with a nonzero code turns on. A channel then stays on until the counter matches its code, so a code of N gives N clock periods of on-time.

The counter saturates at its all-ones value and holds there with every enable low. It stays frozen until `blank` is raised and lowered again. A one-clock `cycleDone` pulse marks the moment the counter first reaches the all-ones value. `counterRun` is high while a cycle is in progress.

The code register is read live, with no shadow copy, so a code changed mid-cycle is compared at once. A system controller typically loads new codes while `blank` is high, between cycles.

Top module: `gray_pwm_engine`

## Requirements
- R1: While `blank` is high, every bit of `chanOn` is 0 in the same cycle, without waiting for a clock edge. At each clock edge that samples `blank` high, the counter is cleared to 0 and `counterRun` and `cycleDone` read 0 afterwards.
- R2: At the first rising clock edge that samples `blank` low with the counter at 0, the counter becomes 1. At that edge channel i turns on exactly when its code, `gsValues[12*i +: 12]`, is nonzero. A channel whose code is 0 stays off for the whole cycle.
- R3: A channel with code N (1 to 4095) stays on for exactly N clock periods, counted from the edge that started the cycle. It turns off at the edge where the counter, before incrementing, equals N.
- R4: Once the counter holds 0xFFF, the next edge leaves it at 0xFFF and turns all channels off. The counter and the outputs then stay frozen until `blank` is raised.
- R5: `cycleDone` is high for exactly one clock period, in the period that begins at the edge where the counter steps from 0xFFE to 0xFFF.
- R6: Raising `blank` in the middle of a cycle turns all outputs off at once. The next clock edge returns the counter to 0, so lowering `blank` again starts a fresh cycle that follows R2.
- R7: A code rewritten mid-cycle is used in the very next comparison. If the new code is above the current count, the channel turns off when the counter reaches the new code. If it is at or below the current count, no match can occur, and the channel stays on until the freeze of R4.
- R8: `counterRun` is high exactly while `blank` is low and the counter lies between 1 and 0xFFE inclusive.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| gsClk | input | 1 | Grayscale reference clock; all state changes on its rising edge |
| blank | input | 1 | High: outputs forced off and counter cleared; falling edge starts a cycle |
| gsValues | input | 192 | Sixteen 12-bit codes; channel i occupies bits 12*i+11 down to 12*i |
| chanOn | output | 16 | Per-channel PWM enable, bit i for channel i |
| cycleDone | output | 1 | One-clock pulse when the counter first reaches 0xFFF |
| counterRun | output | 1 | High while a grayscale cycle is counting |

## Verification
The assertions assume that `blank` is a level that is stable around each rising edge of `gsClk`. They also assume that `blank` is high at the first edge, so the counter starts from a known value. The stimulus changes `blank` and `gsValues` only on falling clock edges and holds `blank` high through the opening cycles. The stimulus also rewrites codes mid-cycle on purpose, so the zero-code property is stated only for the start edge and not for the whole cycle.

// File: rtl/gray_pwm_pkg.sv
package gray_pwm_pkg;

  // Strobes from the sequencer to the per-channel datapath, one decision per edge.
  typedef struct packed {
    logic clear;  // blank sampled high: drop everything
    logic start;  // first edge of a cycle: counter leaves zero
    logic step;   // counting edge between start and saturation
    logic hold;   // counter saturated: frozen, outputs off
  } ctrlStrobes_t;

endpackage

// File: rtl/gray_pwm_ctrl.sv
module gray_pwm_ctrl
  import gray_pwm_pkg::*;
#(
  parameter int GS_BITS = 12
) (
  input  logic               gsClk,
  input  logic               blank,
  output ctrlStrobes_t       strobes,
  output logic [GS_BITS-1:0] countQ,
  output logic               cycleDone,
  output logic               counterRun
);

  localparam logic [GS_BITS-1:0] CNT_ZERO = '0;
  localparam logic [GS_BITS-1:0] CNT_MAX  = '1;
  localparam logic [GS_BITS-1:0] CNT_PRE  = CNT_MAX - 1'b1;

  logic atZero;
  logic atMax;
  logic doneQ;

  assign atZero = (countQ == CNT_ZERO);
  assign atMax  = (countQ == CNT_MAX);

  // Exactly one strobe is active per edge.
  always_comb begin
    strobes.clear = blank;
    strobes.start = !blank && atZero;
    strobes.hold  = !blank && atMax;
    strobes.step  = !blank && !atZero && !atMax;
  end

  // Shared grayscale counter: cleared by blank, saturates at all ones.
  always_ff @(posedge gsClk) begin
    if (strobes.clear) begin
      countQ <= CNT_ZERO;
    end else if (strobes.start || strobes.step) begin
      countQ <= countQ + 1'b1;
    end
  end

  // Completion pulse: set only on the step that lands on the maximum.
  always_ff @(posedge gsClk) begin
    if (strobes.clear) begin
      doneQ <= 1'b0;
    end else begin
      doneQ <= strobes.step && (countQ == CNT_PRE);
    end
  end

  assign cycleDone  = doneQ;
  assign counterRun = strobes.step;

endmodule

// File: rtl/gray_pwm_chan.sv
module gray_pwm_chan
  import gray_pwm_pkg::*;
#(
  parameter int GS_BITS = 12,
  parameter int NUM_CH  = 16
) (
  input  logic                      gsClk,
  input  ctrlStrobes_t              strobes,
  input  logic [GS_BITS-1:0]        countQ,
  input  logic [NUM_CH*GS_BITS-1:0] gsValues,
  output logic [NUM_CH-1:0]         onQ
);

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    logic [GS_BITS-1:0] codeVal;
    logic               codeNonZero;
    logic               codeMatch;

    assign codeVal     = gsValues[ch*GS_BITS +: GS_BITS];
    assign codeNonZero = |codeVal;
    assign codeMatch   = (codeVal == countQ);

    // Set only on the start edge, cleared on match, saturation or blank.
    always_ff @(posedge gsClk) begin
      if (strobes.clear) begin
        onQ[ch] <= 1'b0;
      end else if (strobes.start) begin
        onQ[ch] <= codeNonZero;
      end else if (strobes.hold) begin
        onQ[ch] <= 1'b0;
      end else if (strobes.step && codeMatch) begin
        onQ[ch] <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/gray_pwm_engine.sv
module gray_pwm_engine
  import gray_pwm_pkg::*;
#(
  parameter int GS_BITS = 12,
  parameter int NUM_CH  = 16
) (
  input  logic                      gsClk,
  input  logic                      blank,
  input  logic [NUM_CH*GS_BITS-1:0] gsValues,
  output logic [NUM_CH-1:0]         chanOn,
  output logic                      cycleDone,
  output logic                      counterRun
);

  ctrlStrobes_t       strobes;
  logic [GS_BITS-1:0] countQ;
  logic [NUM_CH-1:0]  onQ;

  gray_pwm_ctrl #(
    .GS_BITS(GS_BITS)
  ) u_ctrl (
    .gsClk     (gsClk),
    .blank     (blank),
    .strobes   (strobes),
    .countQ    (countQ),
    .cycleDone (cycleDone),
    .counterRun(counterRun)
  );

  gray_pwm_chan #(
    .GS_BITS(GS_BITS),
    .NUM_CH (NUM_CH)
  ) u_chan (
    .gsClk   (gsClk),
    .strobes (strobes),
    .countQ  (countQ),
    .gsValues(gsValues),
    .onQ     (onQ)
  );

  // Blank forces the outputs off without waiting for an edge.
  assign chanOn = onQ & ~{NUM_CH{blank}};

endmodule

// File: rtl/gray_pwm_checker.sv
module gray_pwm_checker #(
  parameter int GS_BITS = 12,
  parameter int NUM_CH  = 16
) (
  input logic                      gsClk,
  input logic                      blank,
  input logic [NUM_CH*GS_BITS-1:0] gsValues,
  input logic [NUM_CH-1:0]         chanOn,
  input logic                      cycleDone,
  input logic                      counterRun,
  input logic [GS_BITS-1:0]        countQ
);

  localparam logic [GS_BITS-1:0] CNT_MAX = '1;

  logic [NUM_CH-1:0] zeroMask;
  always_comb begin
    for (int i = 0; i < NUM_CH; i++) begin
      zeroMask[i] = (gsValues[i*GS_BITS +: GS_BITS] == '0);
    end
  end

  // R1: outputs dark whenever blank is high
  p_blank_dark_r1: assert property (@(posedge gsClk)
    blank |-> (chanOn == '0 && !counterRun));

  // R1 / R6: an edge that samples blank leaves the counter at zero
  p_blank_clears_r6: assert property (@(posedge gsClk)
    blank |=> (countQ == '0));

  // R2: the start edge moves the counter to one and lights no zero-code channel
  p_start_step_r2: assert property (@(posedge gsClk) disable iff (blank)
    (countQ == '0) |=> (countQ == 1));

  p_zero_dark_r2: assert property (@(posedge gsClk) disable iff (blank)
    (countQ == '0 && $stable(gsValues)) |=> ((chanOn & zeroMask) == '0));

  // R3: the counter advances by one on every counting edge
  p_count_step_r3: assert property (@(posedge gsClk) disable iff (blank)
    (countQ != '0 && countQ != CNT_MAX) |=> (countQ == $past(countQ) + 1'b1));

  // R4: saturation freezes the counter and darkens every channel
  p_freeze_r4: assert property (@(posedge gsClk) disable iff (blank)
    (countQ == CNT_MAX) |=> (countQ == CNT_MAX && chanOn == '0));

  // R5: the completion pulse lasts a single period
  p_done_pulse_r5: assert property (@(posedge gsClk) disable iff (blank)
    cycleDone |=> !cycleDone);

  // R8: running status never shows at the frozen maximum
  p_run_idle_r8: assert property (@(posedge gsClk) disable iff (blank)
    (countQ == CNT_MAX) |-> !counterRun);

endmodule

bind gray_pwm_engine gray_pwm_checker #(
  .GS_BITS(GS_BITS),
  .NUM_CH (NUM_CH)
) u_chk (
  .gsClk     (gsClk),
  .blank     (blank),
  .gsValues  (gsValues),
  .chanOn    (chanOn),
  .cycleDone (cycleDone),
  .counterRun(counterRun),
  .countQ    (countQ)
);

// File: tb/gray_pwm_engine_bench.sv
module gray_pwm_engine_bench;

  localparam int GS_BITS = 12;
  localparam int NUM_CH  = 16;
  localparam int MAXC    = (1 << GS_BITS) - 1;

  logic                      gsClk = 1'b0;
  logic                      blank = 1'b1;
  logic [NUM_CH*GS_BITS-1:0] gsValues = '0;
  logic [NUM_CH-1:0]         chanOn;
  logic                      cycleDone;
  logic                      counterRun;

  int total = 0;
  int bad   = 0;

  // Behavioural reference state
  int mCnt = 0;
  int mOn[NUM_CH];
  int mDone = 0;

  always #2 gsClk = ~gsClk;  // 250 MHz

  gray_pwm_engine #(.GS_BITS(GS_BITS), .NUM_CH(NUM_CH)) u_gray_pwm_engine (
    .gsClk(gsClk), .blank(blank), .gsValues(gsValues),
    .chanOn(chanOn), .cycleDone(cycleDone), .counterRun(counterRun)
  );

  function automatic int codeOf(int ch);
    return int'(gsValues[ch*GS_BITS +: GS_BITS]);
  endfunction

  task automatic setCode(int ch, int val);
    gsValues[ch*GS_BITS +: GS_BITS] = val[GS_BITS-1:0];
  endtask

  task automatic check(string req, int actual, int expected);
    total++;
    if (actual != expected) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d (count=%0d)", req, actual, expected, mCnt);
    end
  endtask

  function automatic int expOn();
    int v = 0;
    for (int i = 0; i < NUM_CH; i++) if (mOn[i] != 0 && !blank) v |= (1 << i);
    return v;
  endfunction

  // One clock: update the model at the rising edge, compare at the falling edge.
  task automatic tick();
    @(posedge gsClk);
    if (blank) begin
      mCnt = 0; mDone = 0;
      for (int i = 0; i < NUM_CH; i++) mOn[i] = 0;
    end else if (mCnt == 0) begin
      mCnt = 1; mDone = 0;
      for (int i = 0; i < NUM_CH; i++) mOn[i] = (codeOf(i) != 0);
    end else if (mCnt == MAXC) begin
      mDone = 0;
      for (int i = 0; i < NUM_CH; i++) mOn[i] = 0;
    end else begin
      for (int i = 0; i < NUM_CH; i++) if (codeOf(i) == mCnt) mOn[i] = 0;
      mDone = (mCnt == MAXC - 1);
      mCnt++;
    end
    @(negedge gsClk);
    check("R3 chanOn", int'(chanOn), expOn());
    check("R5 cycleDone", int'(cycleDone), mDone);
    check("R8 counterRun", int'(counterRun), int'(!blank && mCnt != 0 && mCnt != MAXC));
  endtask

  initial begin
    #(4 * 150000);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < NUM_CH; i++) mOn[i] = 0;
    // Reset phase under blank
    for (int i = 0; i < NUM_CH; i++) setCode(i, 7 * i + 3);
    repeat (3) tick();
    check("R1 chanOn under blank", int'(chanOn), 0);
    check("R1 counterRun under blank", int'(counterRun), 0);

    // Full cycle with assorted codes
    setCode(0, 0); setCode(1, 1); setCode(2, 2); setCode(3, 5);
    setCode(4, MAXC); setCode(5, MAXC - 1); setCode(6, 100); setCode(7, 3000);
    blank = 1'b0;
    tick();
    check("R2 start mask", int'(chanOn), 16'hFFFE);
    check("R2 counterRun after start", int'(counterRun), 1);
    tick();
    check("R3 code1 off after one period", int'(chanOn[1]), 0);
    check("R3 code2 still on", int'(chanOn[2]), 1);
    tick();
    check("R3 code2 off after two periods", int'(chanOn[2]), 0);
    while (mCnt < 50) tick();
    setCode(6, 60);   // above count: earlier match
    setCode(7, 10);   // below count: no match until freeze
    while (mCnt < 60) tick();
    check("R7 raised-match channel still on", int'(chanOn[6]), 1);
    tick();
    check("R7 channel off at new code", int'(chanOn[6]), 0);
    check("R7 passed code keeps channel on", int'(chanOn[7]), 1);
    while (mCnt < MAXC) tick();
    check("R5 done pulse at maximum", int'(cycleDone), 1);
    check("R3 code 4095 on at maximum", int'(chanOn[4]), 1);
    check("R3 code 4094 off at maximum", int'(chanOn[5]), 0);
    tick();
    check("R4 all off after freeze", int'(chanOn), 0);
    check("R5 pulse dropped", int'(cycleDone), 0);
    repeat (5) tick();
    check("R4 stays frozen dark", int'(chanOn), 0);
    check("R4 no running while frozen", int'(counterRun), 0);

    // Mid-cycle blank
    blank = 1'b1; tick();
    setCode(0, 9); setCode(6, 300);
    blank = 1'b0;
    while (mCnt < 200) tick();
    check("R6 channel lit before blank", int'(chanOn[6]), 1);
    blank = 1'b1;
    #1;
    check("R6 immediate dark", int'(chanOn), 0);
    check("R6 running drops", int'(counterRun), 0);
    tick();
    blank = 1'b0;
    tick();
    check("R6 restart lights code9", int'(chanOn[0]), 1);
    check("R6 restart from count one", int'(counterRun), 1);
    repeat (9) tick();
    check("R3 code9 off after nine periods", int'(chanOn[0]), 0);
    repeat (20) tick();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule